// File: doc/BRIEF.md
# Coil Current Command Receiver (write-only two-wire target)

This block receives write frames on a two-wire I2C bus and turns them into a held command for a voice coil current driver. SCL and SDA are brought into the system clock domain through a short synchronizer. Start and stop conditions and SCL edges are found by comparing the current and previous synchronized samples.

A frame has four bytes, sent MSB first: a target address byte and then three data bytes. The block pulls SDA low to acknowledge each byte it accepts. The three data bytes carry four fields: a power-down flag, a 10-bit current code, a 3-bit step-size field and a 3-bit step-time field.

The decoded fields are staged while the frame arrives. They are copied into the output register together, in one cycle, and only once the last data byte has been acknowledged. A `standby` output tells the driver to force its current target to zero.

Top module: `coil_cmd_i2c_rx`

## Requirements
- R1: A start condition is SDA falling while SCL is high. It begins a new frame at the address byte. A stop condition is SDA rising while SCL is high. It ends the frame, and the block then ignores the bus until the next start.
- R2: The address byte is acknowledged only when it equals 0x66, which is target address 0110011 followed by a 0 write bit. Any other address byte is not acknowledged, including 0x67 (the read direction). After a rejected address, no data byte is acknowledged and the outputs do not change until the next start.
- R3: `sda_pull_low` rises only after the falling SCL edge that ends the 8th bit of an accepted byte. It falls at the next falling SCL edge, which ends the 9th bit. It stays low while data bits are on the bus.
- R4: In data byte 1, bit 7 sets `pwr_down` and bits 5..0 set `cur_code[9:4]`. Bit 6 is ignored.
- R5: In data byte 2, bits 7..4 set `cur_code[3:0]`. Bits 3..0 are ignored.
- R6: In data byte 3, bits 7..5 set `step_size` and bits 4..2 set `step_time`. Bits 1..0 are ignored.
- R7: All outputs change together, in a single cycle, after the acknowledge of data byte 3. A frame cut short by a stop or a start leaves every output at its previous value.
- R8: A repeated start, whether during a frame or after a rejected address, restarts address matching.
- R9: `rst` high, or `en` low, clears the block on the next clock edge. After that edge `pwr_down` = 0, `cur_code` = 0, `step_size` = 0, `step_time` = 0, `sda_pull_low` = 0 and `standby` = 1.
- R10: `standby` is 1 exactly when `pwr_down` is 1, or `cur_code` is 0, or `en` was low at the last clock edge.
- R11: Once a frame has completed, any further byte before the next start is not acknowledged and has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable. When low, the block is held cleared |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_low | output | 1 | When 1, the pad drives SDA low (acknowledge) |
| pwr_down | output | 1 | Power-down flag |
| cur_code | output | 10 | Current code |
| step_size | output | 3 | Current step-size field |
| step_time | output | 3 | Current step-time field |
| standby | output | 1 | Forces the driver's current target to zero |

## Verification
The hardest condition to reach from the ports is a frame that is interrupted part-way while staged fields from an earlier partial frame are still held inside. Only the atomic commit stops such stale bytes from reaching the outputs. The stimulus mixes randomly truncated frames with complete ones, so that partial frames leave staged data behind. It also issues repeated starts after a rejected address and after one accepted data byte. The random data bytes fill the ignored bit positions with noise. Outputs are checked part-way through a frame, before the stop, as well as after it.

// File: rtl/coil_rx_pkg.sv
package coil_rx_pkg;
  localparam int CODE_W  = 10;
  localparam int STEP_W  = 3;
  localparam int BYTE_W  = 8;
  localparam int HI_W    = CODE_W - 4;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SKIP
  } rx_state_e;

  typedef struct packed {
    logic              pd;
    logic [CODE_W-1:0] code;
    logic [STEP_W-1:0] step_size;
    logic [STEP_W-1:0] step_time;
  } coil_cmd_t;
endpackage

// File: rtl/bus_edge_detect.sv
module bus_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  // index SYNC_STAGES-1 is the synchronized level, SYNC_STAGES the previous one
  logic [SYNC_STAGES:0] scl_pipe;
  logic [SYNC_STAGES:0] sda_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_pipe[SYNC_STAGES-1];
  assign scl_prev = scl_pipe[SYNC_STAGES];
  assign sda_now  = sda_pipe[SYNC_STAGES-1];
  assign sda_prev = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
  assign sda_lvl   = sda_now;
endmodule

// File: rtl/frame_receiver.sv
module frame_receiver
  import coil_rx_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'b0110011
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      scl_rise,
  input  logic      scl_fall,
  input  logic      start_det,
  input  logic      stop_det,
  input  logic      sda_lvl,
  output logic      ack_o,
  output logic      load_o,
  output coil_cmd_t cmd_o
);
  localparam logic [BYTE_W-1:0]    ADDR_WR  = {TARGET_ADDR, 1'b0};
  localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);
  localparam logic [1:0]           LAST_IDX = 2'd3;

  rx_state_e            state;
  logic [BIT_CNT_W-1:0] bit_cnt;
  logic [1:0]           byte_idx;
  logic [BYTE_W-1:0]    shreg;
  coil_cmd_t            stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      ack_o    <= 1'b0;
      load_o   <= 1'b0;
      stage    <= '0;
    end else begin
      load_o <= 1'b0;
      if (start_det) begin
        state    <= ST_RECV;
        bit_cnt  <= '0;
        byte_idx <= '0;
        ack_o    <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        ack_o <= 1'b0;
      end else begin
        case (state)
          ST_RECV: begin
            if (scl_rise && bit_cnt != FULL_CNT) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == FULL_CNT) begin
              if (byte_idx == 2'd0 && shreg != ADDR_WR) begin
                state <= ST_SKIP;
              end else begin
                ack_o <= 1'b1;
                state <= ST_ACK;
                case (byte_idx)
                  2'd1: begin
                    stage.pd                <= shreg[7];
                    stage.code[CODE_W-1:4]  <= shreg[HI_W-1:0];
                  end
                  2'd2: stage.code[3:0] <= shreg[7:4];
                  2'd3: begin
                    stage.step_size <= shreg[7:5];
                    stage.step_time <= shreg[4:2];
                  end
                  default: ;
                endcase
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              ack_o   <= 1'b0;
              bit_cnt <= '0;
              if (byte_idx == LAST_IDX) begin
                load_o <= 1'b1;
                state  <= ST_SKIP;
              end else begin
                byte_idx <= byte_idx + 2'd1;
                state    <= ST_RECV;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cmd_o = stage;

  // R3
  ack_rise_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(scl_fall));

  // R3
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> $past(scl_fall || start_det || stop_det));

  // R2
  addr_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && byte_idx == 2'd0) |-> (shreg == ADDR_WR));

  // R7
  load_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    load_o |-> ($past(ack_o) && byte_idx == LAST_IDX));
endmodule

// File: rtl/cmd_register.sv
module cmd_register
  import coil_rx_pkg::*;
(
  input  logic              clk,
  input  logic              clear,
  input  logic              load,
  input  coil_cmd_t         cmd_in,
  output logic              pd_o,
  output logic [CODE_W-1:0] code_o,
  output logic [STEP_W-1:0] step_size_o,
  output logic [STEP_W-1:0] step_time_o,
  output logic              standby_o
);
  coil_cmd_t held;
  logic      standby_q;

  always_ff @(posedge clk) begin
    if (clear) begin
      held      <= '0;
      standby_q <= 1'b1;
    end else if (load) begin
      held      <= cmd_in;
      standby_q <= cmd_in.pd | (cmd_in.code == '0);
    end
  end

  assign pd_o        = held.pd;
  assign code_o      = held.code;
  assign step_size_o = held.step_size;
  assign step_time_o = held.step_time;
  assign standby_o   = standby_q;

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (clear)
    !load |=> $stable(held));

  // R9
  clear_defaults_chk: assert property (@(posedge clk)
    clear |=> (held == '0 && standby_q));

  // R10
  standby_match_chk: assert property (@(posedge clk) disable iff (clear)
    standby_q == (held.pd || held.code == '0));
endmodule

// File: rtl/coil_cmd_i2c_rx.sv
module coil_cmd_i2c_rx
  import coil_rx_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'b0110011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull_low,
  output logic              pwr_down,
  output logic [CODE_W-1:0] cur_code,
  output logic [STEP_W-1:0] step_size,
  output logic [STEP_W-1:0] step_time,
  output logic              standby
);
  logic clear;
  assign clear = rst | ~en;

  logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic load;
  coil_cmd_t staged;

  bus_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst       (clear),
    .scl_i     (scl_in),
    .sda_i     (sda_in),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl)
  );

  frame_receiver #(.TARGET_ADDR(TARGET_ADDR)) u_frame (
    .clk       (clk),
    .rst       (clear),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl),
    .ack_o     (sda_pull_low),
    .load_o    (load),
    .cmd_o     (staged)
  );

  cmd_register u_cmd (
    .clk         (clk),
    .clear       (clear),
    .load        (load),
    .cmd_in      (staged),
    .pd_o        (pwr_down),
    .code_o      (cur_code),
    .step_size_o (step_size),
    .step_time_o (step_time),
    .standby_o   (standby)
  );

  // R1
  no_ack_while_scl_high_start_chk: assert property (@(posedge clk) disable iff (clear)
    start_det |=> !sda_pull_low);
endmodule

// File: tb/coil_cmd_i2c_rx_bench.sv
module coil_cmd_i2c_rx_bench;
  localparam int Q = 6;
  localparam logic [7:0] GOOD_ADDR = 8'h66;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, en = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_low, pwr_down, standby;
  logic [9:0] cur_code;
  logic [2:0] step_size, step_time;
  wire sda_line = sda_m & ~sda_pull_low;

  coil_cmd_i2c_rx u_coil_cmd_i2c_rx (
    .clk(clk), .rst(rst), .en(en), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull_low(sda_pull_low), .pwr_down(pwr_down), .cur_code(cur_code),
    .step_size(step_size), .step_time(step_time), .standby(standby)
  );

  int checks = 0, errors = 0;
  logic       e_pd = 1'b0;
  logic [9:0] e_code = '0;
  logic [2:0] e_ss = '0, e_st = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_standby();
    return e_pd | (e_code == 10'd0);
  endfunction

  task automatic check_outputs(input string req);
    chk(pwr_down == e_pd, {req, " R4 pd"}, pwr_down, e_pd);
    chk(cur_code == e_code, {req, " R4 R5 code"}, cur_code, e_code);
    chk(step_size == e_ss, {req, " R6 step_size"}, step_size, e_ss);
    chk(step_time == e_st, {req, " R6 step_time"}, step_time, e_st);
    chk(standby == exp_standby(), {req, " R10 standby"}, standby, exp_standby());
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit early = 0;
    bit acked;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(Q);
      if (sda_pull_low) early = 1;
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q / 2);
    acked = sda_pull_low;
    wq(Q - Q / 2);
    scl_m = 1'b0; wq(Q);
    chk(!early, "R3 no pull during data bits", early, 0);
    chk(acked == exp_ack, req, acked, exp_ack);
    if (acked) chk(!sda_pull_low, "R3 release after 9th fall", sda_pull_low, 0);
  endtask

  task automatic send_frame(input logic [7:0] a, input logic [7:0] b1, input logic [7:0] b2,
                            input logic [7:0] b3, input int nbytes, input bit do_stop);
    bit ok = (a == GOOD_ADDR);
    logic [7:0] bytes [4];
    bytes[0] = a; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3;
    bus_start();
    send_byte(a, ok, "R2 address ack");
    for (int k = 1; k < nbytes; k++) send_byte(bytes[k], ok, "R3 data ack");
    if (ok && nbytes == 4) begin
      e_pd = b1[7]; e_code = {b1[5:0], b2[7:4]}; e_ss = b3[7:5]; e_st = b3[4:2];
    end
    if (do_stop) bus_stop();
    wq(4);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    wq(4);
    rst = 1'b0;
    wq(2);
    check_outputs("R9 reset");
    chk(sda_pull_low == 1'b0, "R9 reset sda", sda_pull_low, 0);

    // R4 R5 R6: don't-care bits set to 1
    send_frame(GOOD_ADDR, 8'b0110_1010, 8'b0101_1111, 8'b1010_1111, 4, 1);
    check_outputs("R4 R5 R6 directed");
    // R10: power-down set
    send_frame(GOOD_ADDR, 8'b1000_0001, 8'b0000_0000, 8'b0110_0000, 4, 1);
    check_outputs("R10 pd");
    // R10: zero code
    send_frame(GOOD_ADDR, 8'b0100_0000, 8'b0000_1111, 8'b1111_1100, 4, 1);
    check_outputs("R10 zero code");
    send_frame(GOOD_ADDR, 8'h15, 8'hA0, 8'h48, 4, 1);
    // R2: read direction rejected
    send_frame(8'h67, 8'h3F, 8'hF0, 8'hFC, 4, 1);
    check_outputs("R2 read addr");
    // R7: truncated, check mid-frame and after stop
    send_frame(GOOD_ADDR, 8'h80, 8'h00, 8'hFC, 3, 0);
    check_outputs("R7 mid-frame");
    bus_stop();
    wq(4);
    check_outputs("R7 aborted");
    // R8: wrong address, repeated start, good frame
    send_frame(8'h24, 8'h00, 8'h00, 8'h00, 1, 0);
    send_frame(GOOD_ADDR, 8'h2C, 8'h30, 8'h94, 4, 1);
    check_outputs("R8 restart after reject");
    // R8: partial frame then repeated start
    send_frame(GOOD_ADDR, 8'hBF, 8'hF0, 8'hFC, 2, 0);
    send_frame(GOOD_ADDR, 8'h01, 8'h10, 8'h20, 4, 1);
    check_outputs("R8 R7 restart mid-frame");
    // R11: extra byte after full frame
    send_frame(GOOD_ADDR, 8'h0A, 8'hB0, 8'hE4, 4, 0);
    send_byte(8'hFF, 1'b0, "R11 extra byte ack");
    bus_stop();
    wq(4);
    check_outputs("R11 extra byte");

    // random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] a;
      int nb;
      a = GOOD_ADDR;
      if ($urandom % 5 == 0) begin
        a = 8'($urandom);
        if (a == GOOD_ADDR) a = 8'h67;
      end
      nb = ($urandom % 4 == 0) ? 1 + int'($urandom % 3) : 4;
      send_frame(a, 8'($urandom), 8'($urandom), 8'($urandom), nb, 1);
      check_outputs(nb == 4 ? "R1 random" : "R7 random truncated");
    end

    // R9 R10: enable low clears
    send_frame(GOOD_ADDR, 8'h3F, 8'hF0, 8'hFC, 4, 1);
    check_outputs("R9 before disable");
    en = 1'b0;
    wq(2);
    e_pd = 0; e_code = 0; e_ss = 0; e_st = 0;
    check_outputs("R9 enable low");
    chk(standby == 1'b1, "R10 standby while disabled", standby, 1);
    en = 1'b1;
    wq(2);
    send_frame(GOOD_ADDR, 8'h12, 8'h30, 8'hA8, 4, 1);
    check_outputs("R9 after re-enable");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule